// File: doc/BRIEF.md
# Edge-Selected Input Capture Unit

This block takes a snapshot of a free-running counter when a chosen transition appears on an external input. The input goes through a two-flop synchroniser. The synchronised level is compared with the level stored one cycle earlier. When the selected transition is seen, the counter value present at that clock edge is written into a 16-bit capture register. A capture flag is raised at the same edge.

Software reads the captured value as a low byte and a high byte. It clears the flag by writing a one to it. When the waveform generator uses the capture register as its TOP value, the unit stops capturing. The counter is not part of this block; it arrives as an input bus.

Top module: `capture_unit`

## Requirements
- R1: After reset, capValue is 0 and capFlag is 0. The stored input level is 0, and the synchroniser stages are also 0.
- R2: With edgeRising = 1, a 0-to-1 change on capPin causes a capture. A 1-to-0 change causes no capture.
- R3: With edgeRising = 0, a 1-to-0 change on capPin causes a capture. A 0-to-1 change causes no capture.
- R4: Suppose capPin changes just before clock edge k. The capture register then takes the count value present at edge k+2, and it does not change at edges k or k+1.
- R5: capLo always equals capValue bits 7:0, and capHi always equals capValue bits 15:8.
- R6: Every capture sets capFlag. The flag then stays at 1 until it is cleared by a write.
- R7: A cycle with clrWr = 1 and clrData = 1 clears capFlag at the next edge. A cycle with clrWr = 1 and clrData = 0 leaves capFlag unchanged.
- R8: If a capture and a clearing write fall on the same edge, the capture wins and capFlag ends at 1.
- R9: While topIsCapture = 1, a selected edge changes neither capValue nor capFlag. The edge is also not remembered for later.
- R10: A new capture overwrites the held value even when capFlag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| capPin | input | 1 | Asynchronous capture input |
| count | input | 16 | Running counter value |
| edgeRising | input | 1 | 1 selects the rising edge; 0 selects the falling edge |
| topIsCapture | input | 1 | 1 when the waveform mode uses the capture register as TOP |
| clrWr | input | 1 | Write strobe to the flag bit |
| clrData | input | 1 | Data written to the flag bit; 1 clears it |
| capValue | output | 16 | Capture register |
| capLo | output | 8 | Capture register, low byte |
| capHi | output | 8 | Capture register, high byte |
| capFlag | output | 1 | Capture flag |

## Verification
The assertions check three things on every cycle:
- the register changes only on a load strobe, and a load stores the counter value sampled at that edge;
- no load happens while the register serves as TOP;
- the flag rises only on a load, and a clearing write without a load leaves it low.

Some behaviours only the bench scenarios can show, because they tie pin activity to outputs:
- the two-edge synchroniser latency;
- the correct edge polarity for each select value;
- the fact that an edge seen during suppression is forgotten;
- the set-over-clear priority.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef struct packed {
    logic load;
    logic setFlag;
    logic clrFlag;
  } capStrobes_t;
endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        capPin,
  input  logic        edgeRising,
  input  logic        topIsCapture,
  input  logic        clrWr,
  input  logic        clrData,
  output capStrobes_t strb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic prevLevel;
  logic syncLevel;
  logic riseSeen;
  logic fallSeen;
  logic edgeHit;

  // synchroniser chain: stage 0 samples the pin, each later stage follows
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= capPin;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= 1'b0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign syncLevel = syncQ[LAST];

  // previous level tracks always, so edges during suppression are consumed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= syncLevel;
  end

  assign riseSeen = syncLevel & ~prevLevel;
  assign fallSeen = ~syncLevel & prevLevel;
  assign edgeHit  = edgeRising ? riseSeen : fallSeen;

  always_comb begin
    strb.load    = edgeHit & ~topIsCapture;
    strb.setFlag = edgeHit & ~topIsCapture;
    strb.clrFlag = clrWr & clrData;
  end
endmodule

// File: rtl/cap_data.sv
module cap_data
  import cap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] count,
  input  capStrobes_t      strb,
  output logic [CNT_W-1:0] capValue,
  output logic             capFlag
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          capValue <= '0;
    else if (strb.load) capValue <= count;
  end

  // a capture outranks a clearing write on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             capFlag <= 1'b0;
    else if (strb.setFlag) capFlag <= 1'b1;
    else if (strb.clrFlag) capFlag <= 1'b0;
  end
endmodule

// File: rtl/capture_unit.sv
module capture_unit
  import cap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capPin,
  input  logic [CNT_W-1:0] count,
  input  logic             edgeRising,
  input  logic             topIsCapture,
  input  logic             clrWr,
  input  logic             clrData,
  output logic [CNT_W-1:0] capValue,
  output logic [7:0]       capLo,
  output logic [CNT_W-9:0] capHi,
  output logic             capFlag
);
  capStrobes_t strb;

  cap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .capPin(capPin), .edgeRising(edgeRising),
    .topIsCapture(topIsCapture), .clrWr(clrWr), .clrData(clrData), .strb(strb)
  );

  cap_data #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .count(count), .strb(strb),
    .capValue(capValue), .capFlag(capFlag)
  );

  assign capLo = capValue[7:0];
  assign capHi = capValue[CNT_W-1:8];
endmodule

// File: rtl/cap_checker.sv
module cap_checker
  import cap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] count,
  input logic             topIsCapture,
  input capStrobes_t      strb,
  input logic [CNT_W-1:0] capValue,
  input logic             capFlag
);
  // R4 / R10: a load stores the count seen at that edge and raises the flag (R6)
  assert_load_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (capValue == $past(count)) && capFlag);

  // R9: nothing is loaded while the register is TOP
  assert_no_capture_as_top_R9: assert property (@(posedge clk) disable iff (!rstN)
    topIsCapture |=> $stable(capValue));

  // R4: the register holds between loads
  assert_hold_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(capValue));

  // R6: the flag only rises on a capture
  assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capFlag) |-> $past(strb.load));

  // R7: a clearing write without a capture drops the flag
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlag && !strb.setFlag) |=> !capFlag);
endmodule

bind capture_unit cap_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .count(count), .topIsCapture(topIsCapture),
  .strb(strb), .capValue(capValue), .capFlag(capFlag)
);

// File: tb/tb_capture_unit.sv
`timescale 1ns/1ps
module tb_capture_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        capPin = 1'b0;
  logic [15:0] count = '0;
  logic        edgeRising = 1'b0;
  logic        topIsCapture = 1'b0;
  logic        clrWr = 1'b0;
  logic        clrData = 1'b0;
  logic [15:0] capValue;
  logic [7:0]  capLo;
  logic [7:0]  capHi;
  logic        capFlag;

  int applied = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  capture_unit dut (
    .clk(clk), .rstN(rstN), .capPin(capPin), .count(count),
    .edgeRising(edgeRising), .topIsCapture(topIsCapture),
    .clrWr(clrWr), .clrData(clrData),
    .capValue(capValue), .capLo(capLo), .capHi(capHi), .capFlag(capFlag)
  );

  // {rise, top, pin, count, expectCapture}
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b1, 16'h1234, 1'b1},  // R2 rising captured
    {1'b1, 1'b0, 1'b0, 16'h1111, 1'b0},  // R2 falling ignored
    {1'b0, 1'b0, 1'b1, 16'h2222, 1'b0},  // R3 rising ignored
    {1'b0, 1'b0, 1'b0, 16'hABCD, 1'b1},  // R3 falling captured
    {1'b1, 1'b1, 1'b1, 16'h5555, 1'b0},  // R9 suppressed
    {1'b1, 1'b0, 1'b0, 16'h6666, 1'b0},
    {1'b1, 1'b0, 1'b1, 16'hBEEF, 1'b1},
    {1'b0, 1'b1, 1'b0, 16'h7777, 1'b0},  // R9 suppressed
    {1'b0, 1'b0, 1'b1, 16'h8888, 1'b0},
    {1'b0, 1'b0, 1'b0, 16'h00FF, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  endtask

  task automatic clearFlag(input logic dataBit);
    @(negedge clk); clrWr = 1'b1; clrData = dataBit;
    @(negedge clk); clrWr = 1'b0; clrData = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      finishRun();
    end
  end

  initial begin
    logic [15:0] expVal;
    logic [15:0] c0;
    expVal = '0;
    repeat (3) @(negedge clk);
    check("R1 value", capValue, 0);
    check("R1 flag", capFlag, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 value after release", capValue, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      edgeRising = VEC[i][19]; topIsCapture = VEC[i][18];
      capPin = VEC[i][17]; count = VEC[i][16:1];
      repeat (4) @(negedge clk);
      if (VEC[i][0]) expVal = VEC[i][16:1];
      check($sformatf("R2/R3/R9 vec%0d value", i), capValue, expVal);
      check($sformatf("R6/R9 vec%0d flag", i), capFlag, VEC[i][0]);
      check($sformatf("R5 vec%0d bytes", i), {capHi, capLo}, expVal);
      if (VEC[i][0]) begin
        clearFlag(1'b0);
        check("R7 write zero keeps flag", capFlag, 1);
        clearFlag(1'b1);
        check("R7 write one clears flag", capFlag, 0);
      end
    end
    topIsCapture = 1'b0;

    // R4 latency: pin rises with count C0; count increments every negedge
    edgeRising = 1'b1;
    @(negedge clk); c0 = 16'h4000; count = c0; capPin = 1'b1;
    for (int j = 1; j <= 5; j++) begin
      @(negedge clk);
      count = count + 16'd1;
      if (j <= 2) check($sformatf("R4 hold at step %0d", j), capValue, expVal);
      if (j == 3) check("R4 captured value", capValue, c0 + 16'd2);
    end
    expVal = c0 + 16'd2;

    // R10: flag still set, a falling capture replaces the value
    edgeRising = 1'b0;
    @(negedge clk); count = 16'h9A9A; capPin = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 overwrite value", capValue, 16'h9A9A);
    check("R6 flag stays set", capFlag, 1);
    clearFlag(1'b1);
    check("R7 cleared before R8", capFlag, 0);

    // R8: clearing write held across the capture edge (k+2)
    edgeRising = 1'b1;
    @(negedge clk); count = 16'h0C0C; capPin = 1'b1;
    @(negedge clk);
    @(negedge clk); clrWr = 1'b1; clrData = 1'b1;
    @(negedge clk); clrWr = 1'b0; clrData = 1'b0;
    check("R8 set beats clear", capFlag, 1);
    check("R8 value", capValue, 16'h0C0C);

    // R9: edge during suppression is not remembered
    clearFlag(1'b1);
    topIsCapture = 1'b1;
    @(negedge clk); count = 16'h3333; capPin = 1'b0; edgeRising = 1'b0;
    repeat (4) @(negedge clk);
    topIsCapture = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 no late capture value", capValue, 16'h0C0C);
    check("R9 no late capture flag", capFlag, 0);

    // R1: reset mid-run clears everything
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R1 reset value", capValue, 0);
    check("R1 reset flag", capFlag, 0);
    finishRun();
  end
endmodule